// File: doc/BRIEF.md
# I2C Register Target with Deferred Commit

This block is an I2C-compatible target that gives an external bus host access to a byte-wide register file inside the chip. The host first sends the device address with the write bit, then a two-byte register offset. It can then write a block of bytes or read bytes back. Reads work in two ways: with a repeated start after the offset, or as a current-address read that continues from the internal pointer. The pointer advances by one for every byte transferred.

Write bytes do not reach the register file as they are acknowledged. They collect in a 16-entry staging buffer and are copied into their registers in a single clock cycle when STOP is seen. Chip logic that reads the register outputs therefore never sees a partly written block. A new START without a STOP throws the staged bytes away.

The 7-bit device address is made of bits 6..2 of register 0 with the two strap pins in the low two bits. SCL and SDA are sampled with a two-flop synchroniser in the system clock domain. SDA is driven only through an open-drain enable.

Top module: `i2c_commit_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {register 0 bits 6..2, addr_strap[1:0]}. Any other address gets no acknowledge, and the block then ignores the bus until the next START.
- R2: After the address with write (bit 0 = 0), the next two bytes form a 16-bit offset, high byte first. The low log2(REG_COUNT) bits of the offset select the register, and the upper bits are ignored.
- R3: Accepted write bytes leave every bit of reg_q unchanged until STOP. At STOP, all staged bytes appear on reg_q in the same clock cycle.
- R4: Consecutive data bytes, in both directions, use consecutive registers in ascending order. The index wraps from REG_COUNT-1 to 0.
- R5: Every byte on SDA, in either direction, is sent most significant bit first.
- R6: The staging buffer holds STAGE_DEPTH bytes. The byte after the buffer is full is not acknowledged and is dropped, and the bytes already staged are still committed at STOP.
- R7: A START or repeated START that arrives while bytes are staged discards them, and no register changes.
- R8: In a sequential read (offset write, repeated START, address with read bit = 1), the block returns bytes starting at the offset. It keeps sending while the host acknowledges and stops after the host's NACK.
- R9: An address with the read bit given directly returns data from the current pointer. The pointer is one past the last byte transferred.
- R10: While rst_n is low, the block drives no acknowledge and no data, and the registers take their defaults (register 0 = ADDR_REG_RST, all others 0). Bytes staged before the reset are lost.
- R11: sda_oe changes only while SCL is low; it never changes during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level sampled from the pad |
| sda_i | input | 1 | SDA level sampled from the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| addr_strap | input | 2 | Strap pins that supply the low two device address bits |
| reg_q | output | REG_COUNT*8 | Contents of the register file; byte j sits at bits 8j+7..8j |

## Verification
The bench builds the block with its defaults: 64 registers and a 16-byte staging buffer. With these values every one of the 128 device addresses can be swept, and the whole register image can be compared after each STOP. It watches reg_q on every cycle around each STOP to show that no commit arrives partly done. The small register count lets short blocks wrap past register 63 and fill the buffer to its limit plus one byte. A large offset shows that the upper offset bits alias onto the same registers.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C register target.
package i2cs_pkg;
    // Bus-level state of the target
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_st_e;

    // Which byte of a write-direction transfer is being received
    typedef enum logic [1:0] {
        PH_DEV,
        PH_OFS_HI,
        PH_OFS_LO,
        PH_DATA
    } rx_ph_e;
endpackage

// File: rtl/i2cs_line_cond.sv
// Line conditioner: brings SCL/SDA into the clk domain through two flops
// and detects SCL edges and START/STOP conditions.
// Assumes clk runs at least ~10x faster than SCL.
module i2cs_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_d, sda_d;

    // Two-flop synchroniser plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    assign scl_s     = scl_ff[1];
    assign sda_s     = sda_ff[1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_stage.sv
// Staging buffer: collects write bytes in order until they are committed
// or discarded. Pushes while full are ignored by the buffer.
module i2cs_stage #(
    parameter int DEPTH = 16,
    localparam int SW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [7:0]         din,
    output logic [CW-1:0]      cnt,
    output logic               full,
    output logic [DEPTH*8-1:0] data_flat
);
    logic [7:0] mem [DEPTH];

    assign full = (cnt == CW'(DEPTH));

    // Fill count: cleared on commit/discard, advanced on each accepted push
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + 1'b1;
    end

    // Byte storage; contents matter only below cnt, so no reset
    always_ff @(posedge clk) begin
        if (push && !full && !clear)
            mem[cnt[SW-1:0]] <= din;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign data_flat[g*8 +: 8] = mem[g];
    end

    // R6
    stage_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R6
    push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> (cnt == CW'(DEPTH)));
    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/i2cs_regfile.sv
// Register file with a one-cycle block commit: every register whose index
// lies in [base, base+cnt) modulo REG_COUNT loads its staged byte at once.
// Assumes REG_COUNT is a power of two and not smaller than DEPTH.
module i2cs_regfile #(
    parameter int          REG_COUNT = 64,
    parameter int          DEPTH     = 16,
    parameter logic [7:0]  RST0      = 8'h50,
    localparam int AW = $clog2(REG_COUNT),
    localparam int SW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [AW-1:0]          base,
    input  logic [CW-1:0]          cnt,
    input  logic [DEPTH*8-1:0]     stage_flat,
    output logic [REG_COUNT*8-1:0] reg_flat
);
    for (genvar j = 0; j < REG_COUNT; j++) begin : g_reg
        localparam logic [7:0] RV = (j == 0) ? RST0 : 8'h00;
        logic [AW-1:0] rel;
        assign rel = AW'(j) - base;

        // One register: default on reset, staged byte on a covering commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_flat[j*8 +: 8] <= RV;
            else if (commit && (32'(rel) < 32'(cnt)))
                reg_flat[j*8 +: 8] <= stage_flat[{rel[SW-1:0], 3'b000} +: 8];
        end
    end

    // R3
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(reg_flat));
endmodule

// File: rtl/i2c_commit_target.sv
// I2C register target with deferred commit. Decodes address, two offset
// bytes and data. Write data goes to a staging buffer that is committed at
// STOP. Reads come from the committed registers at an auto-incrementing
// pointer. No clock stretching; 7-bit addressing only.
module i2c_commit_target #(
    parameter int         REG_COUNT    = 64,
    parameter int         STAGE_DEPTH  = 16,
    parameter logic [7:0] ADDR_REG_RST = 8'h50
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [1:0]             addr_strap,
    output logic [REG_COUNT*8-1:0] reg_q
);
    import i2cs_pkg::*;

    localparam int AW = $clog2(REG_COUNT);
    localparam int CW = $clog2(STAGE_DEPTH + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_st_e state;
    rx_ph_e  phase;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg, ofs_hi, rd_byte;
    logic [15:0] ptr, ofs_full;
    logic [AW-1:0] wbase;
    logic rd_dir, m_ack;
    logic [6:0] dev_addr;
    logic [CW-1:0] stg_cnt;
    logic stg_full, stg_push, stg_clear, stg_commit;
    logic [STAGE_DEPTH*8-1:0] stg_flat;

    i2cs_line_cond u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign dev_addr   = {reg_q[6:2], addr_strap};
    assign ofs_full   = {ofs_hi, shreg};
    assign rd_byte    = reg_q[{ptr[AW-1:0], 3'b000} +: 8];
    assign stg_push   = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8)
                        && (phase == PH_DATA) && !stg_full;
    assign stg_commit = stop_det && (stg_cnt != '0);
    assign stg_clear  = start_det || stg_commit;
    assign sda_oe     = (state == ST_RX_ACK) || ((state == ST_TX) && !shreg[7]);

    i2cs_stage #(.DEPTH(STAGE_DEPTH)) u_stage (
        .clk(clk), .rst_n(rst_n), .clear(stg_clear), .push(stg_push),
        .din(shreg), .cnt(stg_cnt), .full(stg_full), .data_flat(stg_flat)
    );

    i2cs_regfile #(.REG_COUNT(REG_COUNT), .DEPTH(STAGE_DEPTH), .RST0(ADDR_REG_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(stg_commit), .base(wbase),
        .cnt(stg_cnt), .stage_flat(stg_flat), .reg_flat(reg_q)
    );

    // Bus protocol engine: byte shifting, decoding, acknowledge and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_DEV;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            ofs_hi  <= '0;
            wbase   <= '0;
            rd_dir  <= 1'b0;
            m_ack   <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RX;
            phase   <= PH_DEV;
            bit_cnt <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        case (phase)
                            PH_DEV: begin
                                if (shreg[7:1] == dev_addr) begin
                                    state  <= ST_RX_ACK;
                                    rd_dir <= shreg[0];
                                    phase  <= PH_OFS_HI;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            PH_OFS_HI: begin
                                ofs_hi <= shreg;
                                phase  <= PH_OFS_LO;
                                state  <= ST_RX_ACK;
                            end
                            PH_OFS_LO: begin
                                ptr   <= ofs_full;
                                wbase <= ofs_full[AW-1:0];
                                phase <= PH_DATA;
                                state <= ST_RX_ACK;
                            end
                            default: begin
                                if (!stg_full) begin
                                    ptr   <= ptr + 16'd1;
                                    state <= ST_RX_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_dir) begin
                            state <= ST_TX;
                            shreg <= rd_byte;
                            ptr   <= ptr + 16'd1;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            state <= ST_TX_ACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            state   <= ST_TX;
                            shreg   <= rd_byte;
                            ptr     <= ptr + 16'd1;
                            bit_cnt <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);
    // R11
    sda_steady_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

// File: tb/test_i2c_commit_target.sv
// Bench: bus-functional I2C host driving the target; reference register
// image kept in the bench and compared on every cycle around each STOP.
module test_i2c_commit_target;
    localparam int NREG  = 64;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic sda_oe;
    logic sda_bus;
    logic [NREG*8-1:0] reg_q;

    assign sda_bus = sda_m & ~sda_oe;
    always #10 clk = ~clk;

    i2c_commit_target i_i2c_commit_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .addr_strap(strap), .reg_q(reg_q)
    );

    int checks = 0;
    int errors = 0;
    int r11_viol = 0;
    logic [7:0] exp_r [NREG];
    logic [7:0] nxt_r [NREG];
    logic [6:0] dev = 7'h51;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    // R11 monitor: sda_oe must not move while SCL stays high
    always @(negedge clk) begin
        if (rst_n && scl_prev && scl_m && (sda_oe !== oe_prev)) r11_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    function automatic logic [7:0] rq(int j);
        return reg_q[j*8 +: 8];
    endfunction

    function automatic int changed_count();
        int c = 0;
        for (int j = 0; j < NREG; j++) if (rq(j) !== exp_r[j]) c++;
        return c;
    endfunction

    function automatic int pending_count();
        int c = 0;
        for (int j = 0; j < NREG; j++) if (nxt_r[j] !== exp_r[j]) c++;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic qwait();
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic write_byte(input logic [7:0] v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    // STOP, then watch every cycle that the commit is never partial (R3)
    task automatic stop_commit(input string req);
        int npend = pending_count();
        bit torn = 1'b0;
        int c;
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            c = changed_count();
            if (c != 0 && c != npend) torn = 1'b1;
        end
        chk(!torn, "R3 commit seen partly done", int'(torn), 0);
        for (int j = 0; j < NREG; j++) begin
            chk(rq(j) === nxt_r[j], req, int'(rq(j)), int'(nxt_r[j]));
            exp_r[j] = nxt_r[j];
        end
    endtask

    // Address, offset and n data bytes; no STOP. keep=1 records expected commit
    task automatic write_block(input logic [15:0] ofs, input int n, input int seed, input bit keep);
        bit ack;
        logic [7:0] v;
        int idx;
        bus_start();
        write_byte({dev, 1'b0}, ack);
        chk(ack, "R1 own address acknowledged", int'(ack), 1);
        write_byte(ofs[15:8], ack);
        chk(ack, "R2 offset high byte acknowledged", int'(ack), 1);
        write_byte(ofs[7:0], ack);
        chk(ack, "R2 offset low byte acknowledged", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            idx = (int'(ofs[5:0]) + i) % NREG;
            v = (idx == 0) ? 8'h50 : 8'((seed + i * 29) ^ 8'h5A);
            write_byte(v, ack);
            chk(ack == (i < DEPTH), "R6 data ack vs staging space", int'(ack), int'(i < DEPTH));
            if (keep && i < DEPTH) nxt_r[idx] = v;
            chk(changed_count() == 0, "R3 registers unchanged before STOP", changed_count(), 0);
        end
    endtask

    task automatic seq_read(input logic [15:0] ofs, input int n);
        bit ack;
        logic [7:0] v;
        int idx;
        bus_start();
        write_byte({dev, 1'b0}, ack);
        write_byte(ofs[15:8], ack);
        write_byte(ofs[7:0], ack);
        bus_start();
        write_byte({dev, 1'b1}, ack);
        chk(ack, "R8 read address acknowledged", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, v);
            idx = (int'(ofs[5:0]) + i) % NREG;
            chk(v === exp_r[idx], "R5/R8/R4 sequential read data", int'(v), int'(exp_r[idx]));
        end
        bus_stop();
    endtask

    task automatic cur_read(input int first, input int n);
        bit ack;
        logic [7:0] v;
        int idx;
        bus_start();
        write_byte({dev, 1'b1}, ack);
        chk(ack, "R9 current read address acknowledged", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, v);
            idx = (first + i) % NREG;
            chk(v === exp_r[idx], "R9 current read data", int'(v), int'(exp_r[idx]));
        end
        bus_stop();
    endtask

    task automatic set_defaults();
        for (int j = 0; j < NREG; j++) begin
            exp_r[j] = (j == 0) ? 8'h50 : 8'h00;
            nxt_r[j] = exp_r[j];
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ack;
        set_defaults();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: register defaults after reset
        for (int j = 0; j < NREG; j++)
            chk(rq(j) === exp_r[j], "R10 reset default", int'(rq(j)), int'(exp_r[j]));

        // R1: sweep all 128 device addresses with strap 01 (own address 0x51)
        for (int a = 0; a < 128; a++) begin
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            bus_stop();
            chk(ack == (a == 7'h51), "R1 address sweep ack", int'(ack), int'(a == 7'h51));
        end

        // R1: change straps to 10, own address becomes 0x52
        strap = 2'b10;
        dev = 7'h52;
        bus_start(); write_byte({7'h51, 1'b0}, ack); bus_stop();
        chk(!ack, "R1 old address ignored after strap change", int'(ack), 0);
        bus_start(); write_byte({7'h52, 1'b0}, ack); bus_stop();
        chk(ack, "R1 new strap address acknowledged", int'(ack), 1);

        // R3: four-byte block at register 16
        write_block(16'h0010, 4, 17, 1'b1);
        stop_commit("R3 block committed at STOP");

        // R2/R4: high offset bits alias, wrap past register 63
        write_block(16'hFFFE, 5, 90, 1'b1);
        stop_commit("R2/R4 wrapped aliased block");

        // R6: seventeen bytes, last one refused
        write_block(16'h0120, 17, 200, 1'b1);
        stop_commit("R6 first sixteen committed only");

        // Fill registers 48..61 for the read tests
        write_block(16'h0130, 14, 33, 1'b1);
        stop_commit("R3 block at 48 committed");

        // R7: repeated START discards staged bytes
        write_block(16'h0008, 3, 7, 1'b0);
        bus_start();
        write_byte({dev, 1'b0}, ack);
        stop_commit("R7 discarded bytes left registers unchanged");

        // R8/R4: sequential read wraps from 63 to 0
        seq_read(16'h0130, 20);
        // R9: pointer stands at 68 -> registers 4..6
        cur_read(4, 3);
        // R8: whole register file in one read
        seq_read(16'h0000, NREG);

        // R10: reset in the middle of a write block
        write_block(16'h0005, 2, 61, 1'b0);
        rst_n = 1'b0;
        write_byte({dev, 1'b0}, ack);
        chk(!ack, "R10 no acknowledge during reset", int'(ack), 0);
        chk(sda_oe == 1'b0, "R10 SDA released during reset", int'(sda_oe), 0);
        set_defaults();
        for (int j = 0; j < NREG; j++)
            chk(rq(j) === exp_r[j], "R10 defaults while in reset", int'(rq(j)), int'(exp_r[j]));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_stop();
        repeat (12) @(negedge clk);
        chk(changed_count() == 0, "R10 staged bytes lost over reset", changed_count(), 0);
        cur_read(0, 2);

        chk(r11_viol == 0, "R11 sda_oe steady while SCL high", r11_viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule